// File: doc/BRIEF.md
# Virtual Interrupt Flag Control Unit

This unit owns three bits of a processor flags word: the real interrupt-enable flag, a shadow (virtual) interrupt-enable flag, and a virtual-interrupt-pending bit. It carries out the flag-handling instructions: clear interrupts, set interrupts, push flags and pop flags. It also takes two software operations that set or clear the pending bit, and a supervisor write that loads all three bits at once. When the virtual-interrupt extension is enabled and the I/O privilege level is below its maximum, the unit is in virtual mode. In that mode the masking instructions are steered onto the shadow flag and the real flag is left alone. An attempt to raise the shadow flag while an interrupt is pending produces a general-protection fault pulse instead of raising it.

Operations arrive on a valid/ready strobe with a 3-bit opcode and one 32-bit data word. Pushed flag images leave on a one-entry valid/ready output. Back-pressure works as follows. `op_ready` is high when the output register is empty or is being drained in the same cycle. An operation is accepted only on a cycle where both `op_valid` and `op_ready` are high. A pushed image stays valid and unchanged until `psh_ready` is seen high.

Top module: `vif_flag_unit`

## Requirements
- R1: Virtual mode is active exactly when `ext_en`=1 and `iopl`<3. In virtual mode an accepted clear (opcode 0), set (opcode 1) or pop (opcode 3) leaves `if_o` unchanged.
- R2: In virtual mode an accepted clear operation (opcode 0) sets `vif_o` to 0 on the next cycle. An accepted set operation (opcode 1) with `vip_o`=0 sets `vif_o` to 1 on the next cycle.
- R3: An accepted push (opcode 2) produces a pushed image on the next cycle. In virtual mode, bit 9 of that image holds `vif_o`; outside virtual mode, bit 9 holds `if_o`. In both modes, bit 19 holds `vif_o` and bit 20 holds `vip_o`, all taken as they were before the push.
- R4: In virtual mode an accepted pop (opcode 3) loads `vif_o` from bit 9 of `flags_in`, unless R5 blocks it.
- R5: In virtual mode, while `vip_o`=1, a set operation, or a pop whose bit 9 is 1, raises a fault and leaves `vif_o` unchanged.
- R6: `vip_o` changes only through opcode 4 (set to 1), opcode 5 (clear to 0) or opcode 6. Opcodes 4 and 5 work in any mode.
- R7: A supervisor write (opcode 6) loads `if_o`, `vif_o` and `vip_o` from bits 9, 19 and 20 of `flags_in`, in any mode, and never faults.
- R8: Outside virtual mode, clear, set and pop act on `if_o` (pop takes bit 9 of `flags_in`) and leave `vif_o` unchanged.
- R9: `fault_o` is a registered pulse. It is high for exactly the cycle after the accepted operation that caused it, and low at all other times.
- R10: While `psh_valid`=1 and `psh_ready`=0, `op_ready` is 0 and `psh_data` holds steady.
- R11: After reset, `if_o`, `vif_o`, `vip_o`, `fault_o` and `psh_valid` are 0.
- R12: In a pushed image, every bit other than 9, 19 and 20 equals the corresponding bit of `flags_in` at the push. Opcode 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe valid |
| op_ready | output | 1 | Operation can be accepted this cycle |
| op_code | input | 3 | 0 clear, 1 set, 2 push, 3 pop, 4 set pending, 5 clear pending, 6 supervisor write, 7 no-op |
| flags_in | input | 32 | Pop value, push base word or supervisor write value |
| ext_en | input | 1 | Virtual-interrupt extension enable |
| iopl | input | 2 | I/O privilege level |
| if_o | output | 1 | Real interrupt flag |
| vif_o | output | 1 | Virtual interrupt flag |
| vip_o | output | 1 | Virtual interrupt pending |
| fault_o | output | 1 | General-protection fault pulse |
| psh_valid | output | 1 | Pushed image valid |
| psh_ready | input | 1 | Consumer takes pushed image |
| psh_data | output | 32 | Pushed flags image |

## Verification
The bench targets three corner cases. The first is a set or pop-with-1 while pending is high: a design that skipped the pending check would raise `vif_o` and stay silent instead of pulsing `fault_o`. The second is privilege level 3 with the extension enabled: a design that got the mode boundary wrong would send the operations to the shadow flag and leave the real flag stuck. The third is a push held under back-pressure: a design without a stall would take a second push and overwrite the held image. Random traffic over all opcodes, modes and ready patterns runs against a cycle model, which also exposes wrong bit positions in the pushed image and any path other than opcodes 4, 5 and 6 that changes the pending bit.

// File: rtl/vif_pkg.sv
package vif_pkg;
  typedef enum logic [2:0] {
    OP_CLI   = 3'd0,
    OP_STI   = 3'd1,
    OP_PUSHF = 3'd2,
    OP_POPF  = 3'd3,
    OP_SETP  = 3'd4,
    OP_CLRP  = 3'd5,
    OP_MONWR = 3'd6,
    OP_NOP   = 3'd7
  } vif_op_e;

  typedef struct packed {
    logic ifl;
    logic vif;
    logic vip;
  } vif_state_t;
endpackage

// File: rtl/vif_mode_dec.sv
module vif_mode_dec #(
  parameter int IOPL_W = 2
) (
  input  logic              ext_en,
  input  logic [IOPL_W-1:0] iopl,
  output logic              vmode
);
  localparam logic [IOPL_W-1:0] IOPL_TOP = {IOPL_W{1'b1}};
  // Shadow handling only below the most privileged I/O level
  assign vmode = ext_en && (iopl < IOPL_TOP);
endmodule

// File: rtl/vif_next_state.sv
module vif_next_state
  import vif_pkg::*;
(
  input  logic       accept,
  input  vif_op_e    op,
  input  logic       vmode,
  input  vif_state_t cur,
  input  logic       din_if,
  input  logic       din_vif,
  input  logic       din_vip,
  output vif_state_t nxt,
  output logic       fault
);
  always_comb begin
    nxt   = cur;
    fault = 1'b0;
    if (accept) begin
      case (op)
        OP_CLI: begin
          if (vmode) nxt.vif = 1'b0;
          else       nxt.ifl = 1'b0;
        end
        OP_STI: begin
          if (vmode) begin
            if (cur.vip) fault   = 1'b1;
            else         nxt.vif = 1'b1;
          end else begin
            nxt.ifl = 1'b1;
          end
        end
        OP_POPF: begin
          if (vmode) begin
            if (din_if && cur.vip) fault   = 1'b1;
            else                   nxt.vif = din_if;
          end else begin
            nxt.ifl = din_if;
          end
        end
        OP_SETP:  nxt.vip = 1'b1;
        OP_CLRP:  nxt.vip = 1'b0;
        OP_MONWR: begin
          nxt.ifl = din_if;
          nxt.vif = din_vif;
          nxt.vip = din_vip;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vif_push_img.sv
module vif_push_img
  import vif_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IF_POS  = 9,
  parameter int VIF_POS = 19,
  parameter int VIP_POS = 20
) (
  input  logic [DATA_W-1:0] din,
  input  vif_state_t        st,
  input  logic              vmode,
  output logic [DATA_W-1:0] img
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == IF_POS) begin : g_if
      assign img[b] = vmode ? st.vif : st.ifl;
    end else if (b == VIF_POS) begin : g_vif
      assign img[b] = st.vif;
    end else if (b == VIP_POS) begin : g_vip
      assign img[b] = st.vip;
    end else begin : g_pass
      assign img[b] = din[b];
    end
  end
endmodule

// File: rtl/vif_push_buf.sv
module vif_push_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_load,
  input  logic [DATA_W-1:0] in_data,
  output logic              can_take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vif_flag_unit.sv
module vif_flag_unit
  import vif_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IOPL_W  = 2,
  parameter int IF_POS  = 9,
  parameter int VIF_POS = 19,
  parameter int VIP_POS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] flags_in,
  input  logic              ext_en,
  input  logic [IOPL_W-1:0] iopl,
  output logic              if_o,
  output logic              vif_o,
  output logic              vip_o,
  output logic              fault_o,
  output logic              psh_valid,
  input  logic              psh_ready,
  output logic [DATA_W-1:0] psh_data
);
  vif_state_t        st_q, st_d;
  vif_op_e           op;
  logic              vmode, accept, fault_d;
  logic [DATA_W-1:0] img;

  assign op     = vif_op_e'(op_code);
  assign accept = op_valid && op_ready;

  vif_mode_dec #(.IOPL_W(IOPL_W)) u_mode (
    .ext_en(ext_en), .iopl(iopl), .vmode(vmode)
  );

  vif_next_state u_next (
    .accept (accept),
    .op     (op),
    .vmode  (vmode),
    .cur    (st_q),
    .din_if (flags_in[IF_POS]),
    .din_vif(flags_in[VIF_POS]),
    .din_vip(flags_in[VIP_POS]),
    .nxt    (st_d),
    .fault  (fault_d)
  );

  vif_push_img #(
    .DATA_W(DATA_W), .IF_POS(IF_POS), .VIF_POS(VIF_POS), .VIP_POS(VIP_POS)
  ) u_img (
    .din(flags_in), .st(st_q), .vmode(vmode), .img(img)
  );

  vif_push_buf #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_load  (accept && (op == OP_PUSHF)),
    .in_data  (img),
    .can_take (op_ready),
    .out_valid(psh_valid),
    .out_ready(psh_ready),
    .out_data (psh_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      fault_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_o <= fault_d;
    end
  end

  assign if_o  = st_q.ifl;
  assign vif_o = st_q.vif;
  assign vip_o = st_q.vip;
endmodule

// File: rtl/vif_flag_unit_chk.sv
module vif_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_ready,
  input logic [2:0] op_code,
  input logic       ext_en,
  input logic [1:0] iopl,
  input logic       if_o,
  input logic       vif_o,
  input logic       vip_o,
  input logic       fault_o,
  input logic       psh_valid,
  input logic       psh_ready
);
  logic acc, vm;
  assign acc = op_valid && op_ready;
  assign vm  = ext_en && (iopl != 2'b11);

  AST_IF_KEPT_VMODE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && vm && (op_code == 3'd0 || op_code == 3'd1 || op_code == 3'd3) |=> $stable(if_o)); // R1
  AST_CLI_CLEARS_VIF: assert property (@(posedge clk) disable iff (!rst_n)
    acc && vm && op_code == 3'd0 |=> !vif_o); // R2
  AST_FAULT_KEEPS_VIF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $stable(vif_o)); // R5
  AST_VIP_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vip_o) |-> $past(acc && (op_code == 3'd4 || op_code == 3'd6))); // R6
  AST_STI_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !vm && op_code == 3'd1 |=> if_o); // R8
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(acc && vm && vip_o)); // R9
  AST_PUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    psh_valid && !psh_ready |-> !op_ready); // R10
endmodule

bind vif_flag_unit vif_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .ext_en(ext_en), .iopl(iopl), .if_o(if_o),
  .vif_o(vif_o), .vip_o(vip_o), .fault_o(fault_o),
  .psh_valid(psh_valid), .psh_ready(psh_ready)
);

// File: tb/vif_flag_unit_test.sv
module vif_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd7;
  logic [31:0] flags_in = '0;
  logic        ext_en = 1'b0;
  logic [1:0]  iopl = 2'd0;
  logic        psh_ready = 1'b1;
  logic        op_ready, if_o, vif_o, vip_o, fault_o, psh_valid;
  logic [31:0] psh_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected values after the most recent edge
  bit          e_if, e_vif, e_vip, e_flt, e_pv;
  logic [31:0] e_pd;
  string       t_if = "R11", t_vif = "R11", t_vip = "R11", t_pd = "R3";

  always #10 clk = ~clk;

  vif_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .flags_in(flags_in), .ext_en(ext_en), .iopl(iopl),
    .if_o(if_o), .vif_o(vif_o), .vip_o(vip_o), .fault_o(fault_o),
    .psh_valid(psh_valid), .psh_ready(psh_ready), .psh_data(psh_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk({t_if, " if"}, 32'(if_o), 32'(e_if));
    chk({t_vif, " vif"}, 32'(vif_o), 32'(e_vif));
    chk({t_vip, " vip"}, 32'(vip_o), 32'(e_vip));
    chk("R9 fault", 32'(fault_o), 32'(e_flt));
    chk("R10 push valid", 32'(psh_valid), 32'(e_pv));
    if (e_pv) chk({t_pd, " push data"}, psh_data, e_pd);
  endtask

  // Drive one cycle of stimulus and advance the model across the next edge
  task automatic step(input bit v, input int op, input logic [31:0] d,
                      input bit en, input int pl, input bit rdy);
    bit vm, acc, rdy_exp;
    bit n_if, n_vif, n_vip, n_flt, n_pv;
    logic [31:0] n_pd;
    @(negedge clk);
    compare();
    op_valid = v; op_code = 3'(op); flags_in = d;
    ext_en = en; iopl = 2'(pl); psh_ready = rdy;
    vm = en && (pl < 3);
    rdy_exp = !e_pv || rdy;
    #1;
    chk("R10 op ready", 32'(op_ready), 32'(rdy_exp));
    acc = v && rdy_exp;
    n_if = e_if; n_vif = e_vif; n_vip = e_vip; n_flt = 0;
    n_pv = e_pv; n_pd = e_pd;
    t_if = "R8"; t_vif = "R2"; t_vip = "R6";
    if (acc) begin
      case (op)
        0: if (vm) begin n_vif = 0; t_if = "R1"; end else n_if = 0;
        1: if (vm) begin
             t_if = "R1";
             if (e_vip) begin n_flt = 1; t_vif = "R5"; end else n_vif = 1;
           end else n_if = 1;
        3: if (vm) begin
             t_if = "R1"; t_vif = "R4";
             if (d[9] && e_vip) begin n_flt = 1; t_vif = "R5"; end else n_vif = d[9];
           end else n_if = d[9];
        4: n_vip = 1;
        5: n_vip = 0;
        6: begin n_if = d[9]; n_vif = d[19]; n_vip = d[20]; t_if = "R7"; t_vif = "R7"; t_vip = "R7"; end
        default: ;
      endcase
    end
    if (acc && op == 2) begin
      n_pv = 1; n_pd = d;
      n_pd[9] = vm ? e_vif : e_if; n_pd[19] = e_vif; n_pd[20] = e_vip;
      t_pd = (d == 32'hFFFF_FFFF || d == 32'h0) ? "R12" : "R3";
    end else if (rdy) begin
      n_pv = 0;
    end
    e_if = n_if; e_vif = n_vif; e_vip = n_vip; e_flt = n_flt; e_pv = n_pv; e_pd = n_pd;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_if = 0; e_vif = 0; e_vip = 0; e_flt = 0; e_pv = 0; e_pd = '0;
    compare();                                      // R11 reset state
    rst_n = 1'b1;
    // outside virtual mode: real flag (R8)
    step(1, 1, 32'h0, 0, 0, 1);
    step(1, 2, 32'h0, 0, 0, 1);                     // R12 other bits zero, bit 9 from real flag
    // virtual mode: shadow flag (R1, R2, R3, R4)
    step(1, 0, 32'h0, 1, 0, 1);
    step(1, 1, 32'h0, 1, 1, 1);
    step(1, 2, 32'hFFFF_FFFF, 1, 2, 1);             // R3 / R12
    step(1, 3, 32'h0, 1, 0, 1);                     // R4 pop 0
    step(1, 3, 32'h200, 1, 0, 1);                   // R4 pop 1
    step(1, 0, 32'h0, 1, 0, 1);
    // pending blocks the shadow flag (R5, R6, R9)
    step(1, 4, 32'h0, 1, 0, 1);
    step(1, 1, 32'h0, 1, 0, 1);
    step(1, 1, 32'h0, 1, 0, 1);                     // back-to-back faults
    step(1, 3, 32'h200, 1, 0, 1);
    step(1, 3, 32'h0, 1, 0, 1);
    step(1, 7, 32'hFFFF_FFFF, 1, 0, 1);             // R12 no-op
    // supervisor write clears pending, sets shadow flag (R7)
    step(1, 6, 32'h0008_0000, 1, 0, 1);
    step(1, 6, 32'h0010_0200, 0, 3, 1);
    step(1, 5, 32'h0, 0, 3, 1);
    // privilege level 3 boundary (R1, R8)
    step(1, 0, 32'h0, 1, 3, 1);
    step(1, 3, 32'h200, 1, 3, 1);
    // back-pressure (R10)
    step(1, 2, 32'h1234_5678, 1, 0, 0);
    step(1, 2, 32'h0, 1, 0, 0);
    step(1, 1, 32'h0, 1, 0, 0);
    step(0, 0, 32'h0, 1, 0, 1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)), $urandom,
           1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
           1'($urandom_range(0, 2) != 0));
    end
    step(0, 7, 32'h0, 0, 0, 1);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule